// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Count Order

This block sits in front of a synchronous memory array and decides, once per clock, what the array should do in the next cycle and at which word address. It samples a word address, two active-low burst strobes (one for a host, one for a controller), an active-low step input, three chip-enable inputs and a write-request flag. It registers the resulting operation class (idle, read or write), the effective word address and a phase code that tells whether the cycle starts a burst, continues one or holds one.

A burst starts by loading the external address. The upper address bits stay fixed for the whole burst. The low `CW` bits come from a burst counter that walks through the burst in one of two orders. With linear order the counter adds the step count to the start offset, modulo 2^CW. With interleaved order it XORs the start offset with the step count. The order is chosen by a static input. A synchronous active-high reset leaves the sequencer idle with the address and counter cleared.

The two strobes differ in how they are gated. The host strobe is masked by the main enable and always starts a read. The controller strobe is not masked, so it can deselect the block, and it starts a read or a write according to the write request. The other two enables are looked at only in cycles where a strobe takes effect.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `op_kind`=00, `phase`=00 and `cur_addr`=0, and the burst counter is cleared. A cycle with no strobe right after reset stays idle at address 0.
- R2: When `en_main_n`=0, `en_hi`=1, `en_lo_n`=0 and `stb_host_n`=0, the next cycle shows `op_kind`=01 (read), `phase`=01 (begin) and `cur_addr` equal to the sampled `addr_in`. `wr_req` and `step_n` are ignored.
- R3: When `en_main_n`=0, `stb_host_n`=1, `stb_ctl_n`=0, `en_hi`=1 and `en_lo_n`=0, the next cycle shows `phase`=01, `cur_addr`=`addr_in`, and `op_kind`=10 (write) if `wr_req`=1, otherwise 01. `step_n` is ignored.
- R4: When `en_main_n`=1, `stb_host_n` has no effect. In that case `stb_ctl_n`=0 makes the next cycle idle (`op_kind`=00, `phase`=00) with `cur_addr` unchanged.
- R5: When `en_main_n`=0 and a strobe is low but `en_hi`=0 or `en_lo_n`=1, the next cycle is idle with `cur_addr` unchanged. When no strobe takes effect, `en_hi` and `en_lo_n` are ignored.
- R6: With `order_ilv`=0, a continue cycle (no strobe taking effect, `step_n`=0, not idle) moves the low `CW` bits of `cur_addr` to start+k modulo 2^CW, where k is the step count since the load. The upper bits are unchanged and `phase`=10.
- R7: With `order_ilv`=1, the k-th address of a burst has low bits equal to start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R8: After 2^CW addresses the counter wraps, so the next continue returns to the start address in either order.
- R9: A hold cycle (no strobe taking effect, `step_n`=1, not idle) keeps `cur_addr` unchanged and shows `phase`=11.
- R10: In continue and hold cycles, `op_kind` follows `wr_req` (10 when 1, 01 when 0). A read issued in the middle of a write burst steps the counter exactly as any read does.
- R11: While idle, a cycle with no strobe taking effect leaves the sequencer idle with `cur_addr` unchanged, whatever `step_n` is.
- R12: `op_kind` is never 11, and `op_kind`=00 exactly when `phase`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| order_ilv | input | 1 | Count order: 0 linear, 1 interleaved (static during a burst) |
| en_main_n | input | 1 | Main chip enable, active low; masks the host strobe |
| en_hi | input | 1 | Chip enable, active high, sampled only with a strobe |
| en_lo_n | input | 1 | Chip enable, active low, sampled only with a strobe |
| stb_host_n | input | 1 | Host burst strobe, active low; starts reads |
| stb_ctl_n | input | 1 | Controller burst strobe, active low; starts reads or writes |
| step_n | input | 1 | Advance the burst counter, active low |
| wr_req | input | 1 | Write request: 1 write, 0 read |
| addr_in | input | AW | Word address loaded at burst start |
| op_kind | output | 2 | Operation class: 00 idle, 01 read, 10 write |
| phase | output | 2 | Phase: 00 none, 01 begin, 10 continue, 11 hold |
| cur_addr | output | AW | Effective word address for this cycle |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge, and that `order_ilv` only changes between bursts. The linear-step property compares each address with the one before it, so it holds only while the order stays fixed. The bench drives all inputs at the falling edge, never leaves a control input undriven, and changes `order_ilv` only just before a strobe loads a new burst. The interleaved sequence is checked by the bench against start XOR k rather than by a property, because the address that follows under XOR ordering depends on the hidden step count.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } op_e;

  typedef enum logic [1:0] {
    PH_NONE  = 2'b00,
    PH_BEGIN = 2'b01,
    PH_CONT  = 2'b10,
    PH_HOLD  = 2'b11
  } phase_e;

  typedef struct packed {
    op_e    op;
    phase_e ph;
    logic   load;
    logic   step;
  } cmd_t;

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic en_main_n,
  input  logic en_hi,
  input  logic en_lo_n,
  input  logic stb_host_n,
  input  logic stb_ctl_n,
  input  logic step_n,
  input  logic wr_req,
  input  logic active,
  output cmd_t cmd
);

  logic en_side;
  logic host_hit;
  logic ctl_hit;
  op_e  op_req;

  assign en_side  = en_hi & ~en_lo_n;
  assign host_hit = ~en_main_n & ~stb_host_n;
  assign ctl_hit  = ~stb_ctl_n;
  assign op_req   = wr_req ? OP_WRITE : OP_READ;

  always_comb begin
    cmd = '{op: OP_IDLE, ph: PH_NONE, load: 1'b0, step: 1'b0};
    if (host_hit) begin
      if (en_side) begin
        cmd.op   = OP_READ;
        cmd.ph   = PH_BEGIN;
        cmd.load = 1'b1;
      end
    end else if (ctl_hit) begin
      if (!en_main_n && en_side) begin
        cmd.op   = op_req;
        cmd.ph   = PH_BEGIN;
        cmd.load = 1'b1;
      end
    end else if (active) begin
      cmd.op   = op_req;
      cmd.ph   = step_n ? PH_HOLD : PH_CONT;
      cmd.step = ~step_n;
    end
  end

endmodule

// File: rtl/bseq_counter.sv
module bseq_counter #(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          order_ilv,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_nxt
);

  localparam int HW = AW - CW;

  logic [HW-1:0] hi_q, hi_d;
  logic [CW-1:0] start_q, start_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lin_off, ilv_off;

  always_comb begin
    hi_d    = hi_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (load) begin
      hi_d    = addr_in[AW-1:CW];
      start_d = addr_in[CW-1:0];
      cnt_d   = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign lin_off  = start_d + cnt_d;
  assign ilv_off  = start_d ^ cnt_d;
  assign addr_nxt = {hi_d, (order_ilv ? ilv_off : lin_off)};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      hi_q    <= hi_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          order_ilv,
  input  logic          en_main_n,
  input  logic          en_hi,
  input  logic          en_lo_n,
  input  logic          stb_host_n,
  input  logic          stb_ctl_n,
  input  logic          step_n,
  input  logic          wr_req,
  input  logic [AW-1:0] addr_in,
  output logic [1:0]    op_kind,
  output logic [1:0]    phase,
  output logic [AW-1:0] cur_addr
);
  import bseq_pkg::*;

  cmd_t          cmd;
  logic          active;
  logic [AW-1:0] addr_nxt;

  assign active = (op_kind != OP_IDLE);

  bseq_decode u_decode (
    .en_main_n  (en_main_n),
    .en_hi      (en_hi),
    .en_lo_n    (en_lo_n),
    .stb_host_n (stb_host_n),
    .stb_ctl_n  (stb_ctl_n),
    .step_n     (step_n),
    .wr_req     (wr_req),
    .active     (active),
    .cmd        (cmd)
  );

  bseq_counter #(.AW(AW), .CW(CW)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .order_ilv (order_ilv),
    .load      (cmd.load),
    .step      (cmd.step),
    .addr_in   (addr_in),
    .addr_nxt  (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_kind  <= OP_IDLE;
      phase    <= PH_NONE;
      cur_addr <= '0;
    end else begin
      op_kind  <= cmd.op;
      phase    <= cmd.ph;
      cur_addr <= addr_nxt;
    end
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          order_ilv,
  input logic          en_main_n,
  input logic          en_hi,
  input logic          en_lo_n,
  input logic          stb_host_n,
  input logic          stb_ctl_n,
  input logic          step_n,
  input logic          wr_req,
  input logic [AW-1:0] addr_in,
  input logic [1:0]    op_kind,
  input logic [1:0]    phase,
  input logic [AW-1:0] cur_addr
);

  logic no_stb;
  logic side_ok;
  assign no_stb  = stb_ctl_n & (stb_host_n | en_main_n);
  assign side_ok = en_hi & ~en_lo_n;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (op_kind == 2'b00 && phase == 2'b00 && cur_addr == '0));

  // R2
  host_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_main_n && !stb_host_n && side_ok) |=>
      (op_kind == 2'b01 && phase == 2'b01 && cur_addr == $past(addr_in)));

  // R3
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_main_n && stb_host_n && !stb_ctl_n && side_ok) |=>
      (op_kind == ($past(wr_req) ? 2'b10 : 2'b01) && phase == 2'b01 &&
       cur_addr == $past(addr_in)));

  // R4
  main_off_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (en_main_n && !stb_ctl_n) |=> (op_kind == 2'b00 && $stable(cur_addr)));

  // R5
  side_off_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_main_n && !side_ok && (!stb_host_n || !stb_ctl_n)) |=>
      (op_kind == 2'b00 && phase == 2'b00 && $stable(cur_addr)));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!order_ilv && no_stb && !step_n && op_kind != 2'b00) |=>
      (phase == 2'b10 &&
       cur_addr[CW-1:0] == CW'($past(cur_addr[CW-1:0]) + 1'b1) &&
       cur_addr[AW-1:CW] == $past(cur_addr[AW-1:CW])));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (no_stb && step_n && op_kind != 2'b00) |=>
      (phase == 2'b11 && $stable(cur_addr)));

  // R10
  op_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (no_stb && op_kind != 2'b00) |=>
      (op_kind == ($past(wr_req) ? 2'b10 : 2'b01)));

  // R11
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (no_stb && op_kind == 2'b00) |=> (op_kind == 2'b00 && $stable(cur_addr)));

  // R12
  encoding_chk: assert property (@(posedge clk) disable iff (rst)
    (op_kind != 2'b11) && ((op_kind == 2'b00) == (phase == 2'b00)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .order_ilv  (order_ilv),
  .en_main_n  (en_main_n),
  .en_hi      (en_hi),
  .en_lo_n    (en_lo_n),
  .stb_host_n (stb_host_n),
  .stb_ctl_n  (stb_ctl_n),
  .step_n     (step_n),
  .wr_req     (wr_req),
  .addr_in    (addr_in),
  .op_kind    (op_kind),
  .phase      (phase),
  .cur_addr   (cur_addr)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int AW = 16;
  localparam int CW = 2;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          order_ilv = 1'b0;
  logic          en_main_n = 1'b1, en_hi = 1'b0, en_lo_n = 1'b1;
  logic          stb_host_n = 1'b1, stb_ctl_n = 1'b1, step_n = 1'b1, wr_req = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [1:0]    op_kind, phase;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.AW(AW), .CW(CW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .order_ilv(order_ilv),
    .en_main_n(en_main_n), .en_hi(en_hi), .en_lo_n(en_lo_n),
    .stb_host_n(stb_host_n), .stb_ctl_n(stb_ctl_n), .step_n(step_n),
    .wr_req(wr_req), .addr_in(addr_in),
    .op_kind(op_kind), .phase(phase), .cur_addr(cur_addr)
  );

  // Vector fields: [46:43] requirement number, [42:36] controls
  // {en_main_n,en_hi,en_lo_n,stb_host_n,stb_ctl_n,step_n,wr_req},
  // [35:20] addr_in, [19:18] op, [17:16] phase, [15:0] expected address.
  // Linear order throughout.
  localparam logic [46:0] VEC [NV] = '{
    {4'd2,  7'b0100111, 16'h1232, 2'd1, 2'd1, 16'h1232}, // R2 host load, wr ignored
    {4'd6,  7'b0101100, 16'hFFFF, 2'd1, 2'd2, 16'h1233}, // R6
    {4'd6,  7'b0101100, 16'hFFFF, 2'd1, 2'd2, 16'h1230}, // R6 modulo
    {4'd9,  7'b0101110, 16'hFFFF, 2'd1, 2'd3, 16'h1230}, // R9 hold
    {4'd6,  7'b0101100, 16'hFFFF, 2'd1, 2'd2, 16'h1231}, // R6
    {4'd8,  7'b0101100, 16'hFFFF, 2'd1, 2'd2, 16'h1232}, // R8 wrap
    {4'd3,  7'b0101011, 16'h00A1, 2'd2, 2'd1, 16'h00A1}, // R3 write begin
    {4'd10, 7'b0101101, 16'h0000, 2'd2, 2'd2, 16'h00A2}, // R10
    {4'd10, 7'b0101100, 16'h0000, 2'd1, 2'd2, 16'h00A3}, // R10 dummy read steps
    {4'd4,  7'b1100100, 16'h5550, 2'd1, 2'd2, 16'h00A0}, // R4 host strobe masked
    {4'd4,  7'b1101000, 16'h7777, 2'd0, 2'd0, 16'h00A0}, // R4 deselect
    {4'd11, 7'b1101100, 16'h7777, 2'd0, 2'd0, 16'h00A0}, // R11 stays idle
    {4'd5,  7'b0000100, 16'h1111, 2'd0, 2'd0, 16'h00A0}, // R5 en_hi low
    {4'd5,  7'b0111000, 16'h2222, 2'd0, 2'd0, 16'h00A0}, // R5 en_lo_n high
    {4'd3,  7'b0101000, 16'h0F0E, 2'd1, 2'd1, 16'h0F0E}, // R3 read begin
    {4'd10, 7'b0101101, 16'h0000, 2'd2, 2'd2, 16'h0F0F}, // R10
    {4'd5,  7'b0011100, 16'h0000, 2'd1, 2'd2, 16'h0F0C}, // R5 enables ignored
    {4'd9,  7'b0101111, 16'h0000, 2'd2, 2'd3, 16'h0F0C}  // R9 write hold
  };

  task automatic chk(input int req, input logic [1:0] eo, input logic [1:0] ep,
                     input logic [AW-1:0] ea);
    checks++;
    if (op_kind !== eo || phase !== ep || cur_addr !== ea) begin
      errors++;
      $display("FAIL R%0d: op/phase/addr actual %0d/%0d/%h expected %0d/%0d/%h",
               req, op_kind, phase, cur_addr, eo, ep, ea);
    end
  endtask

  task automatic drive(input logic [6:0] c, input logic [AW-1:0] a);
    {en_main_n, en_hi, en_lo_n, stb_host_n, stb_ctl_n, step_n, wr_req} = c;
    addr_in = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, 2'd0, 2'd0, 16'h0000);            // R1 reset state
    rst = 1'b0;
    drive(7'b0101100, 16'h0000);
    chk(1, 2'd0, 2'd0, 16'h0000);            // R1 and R11 idle after reset

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][42:36], VEC[i][35:20]);
      chk(int'(VEC[i][46:43]), VEC[i][19:18], VEC[i][17:16], VEC[i][15:0]);
    end

    // R7 interleaved order from start 01, then R8 wrap
    order_ilv = 1'b1;
    drive(7'b0100111, 16'h0021); chk(7, 2'd1, 2'd1, 16'h0021);
    drive(7'b0101100, 16'h0000); chk(7, 2'd1, 2'd2, 16'h0020);
    drive(7'b0101100, 16'h0000); chk(7, 2'd1, 2'd2, 16'h0023);
    drive(7'b0101100, 16'h0000); chk(7, 2'd1, 2'd2, 16'h0022);
    drive(7'b0101100, 16'h0000); chk(8, 2'd1, 2'd2, 16'h0021);
    // R7 interleaved write burst from start 10
    drive(7'b0101011, 16'h0042); chk(7, 2'd2, 2'd1, 16'h0042);
    drive(7'b0101101, 16'h0000); chk(7, 2'd2, 2'd2, 16'h0043);
    drive(7'b0101101, 16'h0000); chk(7, 2'd2, 2'd2, 16'h0040);
    drive(7'b0101101, 16'h0000); chk(7, 2'd2, 2'd2, 16'h0041);

    // R1 reset in the middle of a burst
    rst = 1'b1;
    drive(7'b0101101, 16'h0000); chk(1, 2'd0, 2'd0, 16'h0000);
    rst = 1'b0;
    drive(7'b0101100, 16'h0000); chk(1, 2'd0, 2'd0, 16'h0000);
    // R7 counter starts at zero steps after reset
    drive(7'b0100110, 16'h0003); chk(7, 2'd1, 2'd1, 16'h0003);
    drive(7'b0101100, 16'h0000); chk(7, 2'd1, 2'd2, 16'h0002);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule